// File: doc/BRIEF.md
# Real-Time Clock Subsecond Counter with Mixed Binary/BCD Second Tick

This block holds the subsecond count of a real-time clock. On every prescaled counting enable it steps a 32-bit down-counter and decides whether the calendar logic that follows should advance its seconds digit. The counter can serve three roles. It can be a plain free-running binary counter. It can be a synchronous prescaler that reloads itself and feeds a BCD calendar. It can also do both at once, in which case the binary count never reloads and the second tick is taken from a selectable window of its low bits.

Software enters initialization mode to change the counting mode, the tick-window selector, the prescaler reload value or the count itself. While that mode is active the counter holds still. Counting resumes from the written value once the mode is left. Configuration writes made outside initialization mode are dropped. The second tick is a single registered pulse, aligned with the count value that caused it.

Top module: `rtc_subsec_core`

## Requirements
- R1: After a synchronous reset the count reads 0, the second pulse is low, the mode is 0 (BCD only), the tick-window selector is 0 and the prescaler reload value is 0.
- R2: The mode field is 2 bits. Value 0 selects BCD calendar only, value 1 selects binary only, and values 2 and 3 both select mixed binary plus BCD.
- R3: In binary-only and mixed modes, each clock with `tick_en` high outside initialization mode lowers the count by one, and the count wraps from 0 to 0xFFFFFFFF. With `tick_en` low the count holds.
- R4: In mixed mode with selector n (0..7), the second pulse is high in the cycle where a counting step has just made bits [7+n:0] of the count all zero. It is low after any other step.
- R5: In BCD-only mode, a counting step taken when the count is 0 loads the prescaler reload value and raises the second pulse. A step that lands on 0 does not raise the pulse.
- R6: In binary-only mode the second pulse never rises.
- R7: While `init_mode` is high the count does not change, whatever `tick_en` does, and no second pulse is produced. A `load_we` in that mode writes `load_val` into the count, and counting after the mode ends continues from that value.
- R8: `cfg_we` and `load_we` have no effect while `init_mode` is low, so the mode, selector, reload value and count all keep their values.
- R9: The second pulse is exactly one clock wide in mixed mode, and it only ever follows a clock in which a counting step was taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Prescaled counting enable, one clock per count |
| init_mode | input | 1 | Initialization mode: freezes the count and opens configuration |
| cfg_we | input | 1 | Writes mode, selector and reload value (initialization mode only) |
| cfg_mode | input | 2 | Mode to write: 0 BCD, 1 binary, 2/3 mixed |
| cfg_sel | input | 3 | Tick-window selector n; window is bits [7+n:0] |
| cfg_presc | input | 32 | Prescaler reload value used in BCD-only mode |
| load_we | input | 1 | Writes `load_val` into the count (initialization mode only) |
| load_val | input | 32 | Start value for the count |
| ss_count | output | 32 | Current subsecond count |
| sec_pulse | output | 1 | One-clock pulse telling the calendar to advance one second |

## Verification
The one-clock-wide pulse assertion assumes that in mixed mode two successive counting steps cannot both land on a zero window. This holds because the smallest window spans 256 counts, so the assertion is limited to mixed mode. In BCD-only mode a reload value of 0 legitimately produces a pulse on every enabled clock. The assertions also take for granted that configuration and loads change state only inside initialization mode, when no step can occur, so a mode change never coincides with a pulse. The directed stimulus always changes mode, selector and count through an initialization window, and it probes each tick window with loads placed one count above a matching and a non-matching boundary.

// File: rtl/rtc_ss_pkg.sv
package rtc_ss_pkg;
  typedef enum logic [1:0] {
    SS_BCD   = 2'd0,
    SS_BIN   = 2'd1,
    SS_MIX_A = 2'd2,
    SS_MIX_B = 2'd3
  } ss_mode_e;

  function automatic logic ss_is_mixed(input ss_mode_e m);
    return m[1];
  endfunction
endpackage

// File: rtl/ss_cfg_regs.sv
module ss_cfg_regs
  import rtc_ss_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             init_mode,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_mode,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic [CNT_W-1:0] cfg_presc,
  output ss_mode_e         mode_q,
  output logic [SEL_W-1:0] sel_q,
  output logic [CNT_W-1:0] presc_q
);
  logic wr_ok;
  assign wr_ok = init_mode && cfg_we;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= SS_BCD;
      sel_q   <= '0;
      presc_q <= '0;
    end else if (wr_ok) begin
      mode_q  <= ss_mode_e'(cfg_mode);
      sel_q   <= cfg_sel;
      presc_q <= cfg_presc;
    end
  end

  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (rst)
    !init_mode |=> ($stable(mode_q) && $stable(sel_q) && $stable(presc_q))); // R8
endmodule

// File: rtl/ss_down_counter.sv
module ss_down_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             init_mode,
  input  logic             tick_en,
  input  logic             load_we,
  input  logic [CNT_W-1:0] load_val,
  input  logic             reload_mode,
  input  logic [CNT_W-1:0] presc,
  output logic             step,
  output logic             at_zero,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic [CNT_W-1:0] cnt_q
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  assign step    = !init_mode && tick_en;
  assign at_zero = (cnt_q == '0);

  always_comb begin
    cnt_nxt = cnt_q;
    if (init_mode) begin
      if (load_we) cnt_nxt = load_val;
    end else if (tick_en) begin
      if (reload_mode && at_zero) cnt_nxt = presc;
      else                        cnt_nxt = cnt_q - ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_nxt;
  end

  AST_FROZEN_IN_INIT: assert property (@(posedge clk) disable iff (rst)
    (init_mode && !load_we) |=> $stable(cnt_q)); // R7
  AST_DECREMENT: assert property (@(posedge clk) disable iff (rst)
    (!init_mode && tick_en && !reload_mode) |=> (cnt_q == $past(cnt_q) - ONE)); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!init_mode && !tick_en) |=> $stable(cnt_q)); // R3
endmodule

// File: rtl/ss_sec_tick.sv
module ss_sec_tick
  import rtc_ss_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int SEL_W  = 3,
  parameter int BASE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             at_zero,
  input  ss_mode_e         mode,
  input  logic [SEL_W-1:0] sel,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic [CNT_W-1:0] cnt_q,
  output logic             sec_pulse
);
  localparam int N_WIN = 1 << SEL_W;

  logic [CNT_W-1:0] win_mask [N_WIN];

  genvar k;
  generate
    for (k = 0; k < N_WIN; k++) begin : g_win
      assign win_mask[k] = {CNT_W{1'b1}} >> (CNT_W - BASE_W - k);
    end
  endgenerate

  logic [CNT_W-1:0] cur_mask;
  logic             fire;
  assign cur_mask = win_mask[sel];

  always_comb begin
    fire = 1'b0;
    if (step) begin
      unique case (mode)
        SS_BCD:           fire = at_zero;
        SS_BIN:           fire = 1'b0;
        SS_MIX_A, SS_MIX_B: fire = ((cnt_nxt & cur_mask) == '0);
        default:          fire = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sec_pulse <= 1'b0;
    else     sec_pulse <= fire;
  end

  AST_BIN_SILENT: assert property (@(posedge clk) disable iff (rst)
    (mode == SS_BIN) |-> !sec_pulse); // R6
  AST_PULSE_AFTER_STEP: assert property (@(posedge clk) disable iff (rst)
    !step |=> !sec_pulse); // R9
  AST_PULSE_ONE_WIDE: assert property (@(posedge clk) disable iff (rst)
    (sec_pulse && ss_is_mixed(mode)) |=> !sec_pulse); // R9
  AST_MIX_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (sec_pulse && ss_is_mixed(mode)) |-> ((cnt_q & cur_mask) == '0)); // R4
endmodule

// File: rtl/rtc_subsec_core.sv
module rtc_subsec_core
  import rtc_ss_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int SEL_W  = 3,
  parameter int BASE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             init_mode,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_mode,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic [CNT_W-1:0] cfg_presc,
  input  logic             load_we,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] ss_count,
  output logic             sec_pulse
);
  ss_mode_e         mode_q;
  logic [SEL_W-1:0] sel_q;
  logic [CNT_W-1:0] presc_q;
  logic             step;
  logic             at_zero;
  logic [CNT_W-1:0] cnt_nxt;
  logic [CNT_W-1:0] cnt_q;

  ss_cfg_regs #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_cfg (
    .clk(clk), .rst(rst), .init_mode(init_mode), .cfg_we(cfg_we),
    .cfg_mode(cfg_mode), .cfg_sel(cfg_sel), .cfg_presc(cfg_presc),
    .mode_q(mode_q), .sel_q(sel_q), .presc_q(presc_q)
  );

  ss_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .init_mode(init_mode), .tick_en(tick_en),
    .load_we(load_we), .load_val(load_val),
    .reload_mode(mode_q == SS_BCD), .presc(presc_q),
    .step(step), .at_zero(at_zero), .cnt_nxt(cnt_nxt), .cnt_q(cnt_q)
  );

  ss_sec_tick #(.CNT_W(CNT_W), .SEL_W(SEL_W), .BASE_W(BASE_W)) u_tick (
    .clk(clk), .rst(rst), .step(step), .at_zero(at_zero), .mode(mode_q),
    .sel(sel_q), .cnt_nxt(cnt_nxt), .cnt_q(cnt_q), .sec_pulse(sec_pulse)
  );

  assign ss_count = cnt_q;

  AST_INIT_NO_PULSE: assert property (@(posedge clk) disable iff (rst)
    init_mode |=> !sec_pulse); // R7
endmodule

// File: tb/rtc_subsec_core_tb.sv
module rtc_subsec_core_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0;
  logic        init_mode = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_mode = '0;
  logic [2:0]  cfg_sel = '0;
  logic [31:0] cfg_presc = '0;
  logic        load_we = 1'b0;
  logic [31:0] load_val = '0;
  logic [31:0] ss_count;
  logic        sec_pulse;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rtc_subsec_core u_dut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .init_mode(init_mode),
    .cfg_we(cfg_we), .cfg_mode(cfg_mode), .cfg_sel(cfg_sel),
    .cfg_presc(cfg_presc), .load_we(load_we), .load_val(load_val),
    .ss_count(ss_count), .sec_pulse(sec_pulse)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic edge_once();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic setup(input logic [1:0] m, input logic [2:0] s,
                       input logic [31:0] p, input logic [31:0] v);
    init_mode = 1'b1; cfg_we = 1'b1; load_we = 1'b1;
    cfg_mode = m; cfg_sel = s; cfg_presc = p; load_val = v;
    edge_once();
    init_mode = 1'b0; cfg_we = 1'b0; load_we = 1'b0;
  endtask

  task automatic tick1(input string req, input logic [31:0] exp_cnt, input logic exp_p);
    tick_en = 1'b1;
    edge_once();
    tick_en = 1'b0;
    chk(req, ss_count, exp_cnt);
    chk(req, {31'b0, sec_pulse}, {31'b0, exp_p});
  endtask

  task automatic t_reset();
    chk("R1 count", ss_count, 32'h0);
    chk("R1 pulse", {31'b0, sec_pulse}, 32'h0);
    tick1("R1 R5 default BCD reload of 0", 32'h0, 1'b1);
    edge_once();
    chk("R9 pulse drops", {31'b0, sec_pulse}, 32'h0);
  endtask

  task automatic t_binary();
    setup(2'd1, 3'd0, 32'h0, 32'h2);
    chk("R7 load", ss_count, 32'h2);
    tick1("R3 R6 bin", 32'h1, 1'b0);
    tick1("R3 R6 bin zero", 32'h0, 1'b0);
    tick1("R3 R6 wrap", 32'hFFFF_FFFF, 1'b0);
    edge_once();
    chk("R3 idle hold", ss_count, 32'hFFFF_FFFF);
  endtask

  task automatic t_mixed_run();
    setup(2'd2, 3'd0, 32'h0, 32'h102);
    tick_en = 1'b1;
    edge_once();
    chk("R4 mix 101", ss_count, 32'h101);
    chk("R4 no pulse", {31'b0, sec_pulse}, 32'h0);
    edge_once();
    chk("R4 mix 100", ss_count, 32'h100);
    chk("R4 pulse", {31'b0, sec_pulse}, 32'h1);
    edge_once();
    chk("R9 one wide", {31'b0, sec_pulse}, 32'h0);
    chk("R3 mix ff", ss_count, 32'hFF);
    tick_en = 1'b0;
  endtask

  task automatic t_mixed_windows();
    setup(2'd3, 3'd3, 32'h0, 32'h801);
    tick1("R2 R4 n3 hit", 32'h800, 1'b1);
    setup(2'd3, 3'd3, 32'h0, 32'h901);
    tick1("R4 n3 miss", 32'h900, 1'b0);
    setup(2'd2, 3'd7, 32'h0, 32'h8001);
    tick1("R4 n7 hit", 32'h8000, 1'b1);
    setup(2'd2, 3'd7, 32'h0, 32'h4001);
    tick1("R4 n7 miss", 32'h4000, 1'b0);
  endtask

  task automatic t_bcd();
    setup(2'd0, 3'd5, 32'h3, 32'h1);
    tick1("R5 land zero no pulse", 32'h0, 1'b0);
    tick1("R2 R5 reload", 32'h3, 1'b1);
    tick1("R5 dec", 32'h2, 1'b0);
    tick1("R5 dec", 32'h1, 1'b0);
    tick1("R5 dec", 32'h0, 1'b0);
    tick1("R5 reload again", 32'h3, 1'b1);
  endtask

  task automatic t_init_freeze();
    setup(2'd2, 3'd0, 32'h0, 32'h101);
    init_mode = 1'b1; tick_en = 1'b1;
    edge_once();
    edge_once();
    chk("R7 frozen", ss_count, 32'h101);
    chk("R7 no pulse", {31'b0, sec_pulse}, 32'h0);
    load_we = 1'b1; load_val = 32'h201;
    edge_once();
    load_we = 1'b0; init_mode = 1'b0; tick_en = 1'b0;
    chk("R7 loaded", ss_count, 32'h201);
    tick1("R7 resume", 32'h200, 1'b1);
  endtask

  task automatic t_locked_cfg();
    setup(2'd1, 3'd0, 32'h0, 32'h102);
    cfg_we = 1'b1; cfg_mode = 2'd2; cfg_sel = 3'd0;
    load_we = 1'b1; load_val = 32'h5555;
    edge_once();
    cfg_we = 1'b0; load_we = 1'b0;
    chk("R8 load ignored", ss_count, 32'h102);
    tick1("R8 mode kept", 32'h101, 1'b0);
    tick1("R8 mode kept binary", 32'h100, 1'b0);
  endtask

  initial begin
    repeat (3) edge_once();
    rst = 1'b0;
    edge_once();
    t_reset();
    t_binary();
    t_mixed_run();
    t_mixed_windows();
    t_bcd();
    t_init_freeze();
    t_locked_cfg();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule